// File: doc/BRIEF.md
# Protected Rheostat Wiper and Control Register

This block holds the wiper position of a digital rheostat and a small control register, and executes commands that an upstream serial receiver has already decoded into an operation code and a data argument. Its output, the wiper code, selects the tap of the resistor network. A code of all zeros places the wiper at terminal A.

Wiper writes are refused until software sets a write-enable bit through a control command. A software reset can still refresh the wiper from the nonvolatile copy while protection is on. Storing the wiper into nonvolatile memory needs its own program-enable bit. A store hands a request and the current wiper code to an external memory sequencer. The block then stays locked until the sequencer acknowledges, and the sequencer's result is latched into a read-only done bit.

The control core is a three-state machine:
- BOOT is entered from reset. Its one transition, BOOT to IDLE, happens unconditionally on the first clock after reset and loads the wiper.
- IDLE executes commands. IDLE to LOCKED is taken on an honoured store command.
- LOCKED waits for the sequencer. LOCKED to IDLE is taken on the sequencer acknowledge.

Top module: `rheo_wiper_ctrl`

## Requirements
- R1: While reset is held, the wiper reads midscale (bit WIDTH-1 set, all other bits clear, 0x200 at the default width). Write enable, program enable, done and busy all read 0. On the first clock after reset the wiper loads the stored value if `nv_present` is 1, and otherwise stays at midscale.
- R2: Operation code 1 with write enable set loads `cmd_arg` into the wiper. The new value is visible after the next clock edge.
- R3: Operation code 1 while write enable is 0 leaves the wiper unchanged.
- R4: Operation code 7 writes the control register. Write enable takes `cmd_arg[1]` and program enable takes `cmd_arg[0]`.
- R5: Operation code 4 reloads the wiper from `nv_word` when `nv_present` is 1, and otherwise sets it to midscale. This happens whatever the state of write enable.
- R6: Operation code 3 with program enable set does three things on the next edge: it raises `store_req` for exactly one cycle, puts the wiper code on `store_word`, and raises `busy`. `busy` stays high until `prog_ack`. With program enable at 0 the command is ignored: no request is made and `busy` stays low.
- R7: While `busy` is high, every command is ignored. The wiper, the control bits and the readback register do not change.
- R8: When `prog_ack` is seen while busy, the done bit takes `prog_ok`. The done bit is cleared when a store is started and does not change otherwise.
- R9: Operation code 2 loads `rdata`. With `cmd_arg[0]`=0 it loads the wiper code. With `cmd_arg[0]`=1 it loads the control word: bit 2 is done, bit 1 is write enable, bit 0 is program enable, and the upper bits are zero.
- R10: Operation codes 0, 5, 6 and 8 to 15 have no effect on the wiper, the control bits or `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | CMD_W | Operation code |
| cmd_arg | input | WIDTH | Data argument |
| nv_present | input | 1 | A nonvolatile value has been stored |
| nv_word | input | WIDTH | Most recent stored wiper value |
| prog_ack | input | 1 | Sequencer finished the store |
| prog_ok | input | 1 | Result of the finished store |
| wiper | output | WIDTH | Wiper position code |
| store_req | output | 1 | One-cycle store request |
| store_word | output | WIDTH | Value to store |
| busy | output | 1 | Store in progress, commands locked |
| wr_en_bit | output | 1 | Wiper write enable |
| prog_en_bit | output | 1 | Program enable |
| done_bit | output | 1 | Store completion status |
| rdata | output | WIDTH | Readback data |

## Verification
The bench builds the block with its default parameters: a 10-bit wiper, which puts midscale at 0x200, and 4-bit operation codes. At this size all sixteen operation codes can be drawn at random, so every unrecognised code is reached alongside the real ones. The 10-bit argument exercises every wiper bit in both writes and readback. Directed sequences cover protected writes, reloads with and without a stored value, stores with program enable on and off, commands sent while locked, and both completion results.

// File: rtl/rheo_pkg.sv
package rheo_pkg;
    typedef enum logic [2:0] {
        OP_NONE,
        OP_WRITE,
        OP_READ,
        OP_STORE,
        OP_RELOAD,
        OP_CTRL
    } rheo_op_t;

    typedef enum logic [1:0] {
        ST_BOOT,
        ST_IDLE,
        ST_LOCKED
    } rheo_state_t;
endpackage

// File: rtl/rheo_decode.sv
module rheo_decode #(
    parameter int CMD_W = 4
) (
    input  logic                 valid_i,
    input  logic [CMD_W-1:0]     code_i,
    output rheo_pkg::rheo_op_t   op_o
);
    import rheo_pkg::*;

    localparam logic [CMD_W-1:0] C_WRITE  = CMD_W'(1);
    localparam logic [CMD_W-1:0] C_READ   = CMD_W'(2);
    localparam logic [CMD_W-1:0] C_STORE  = CMD_W'(3);
    localparam logic [CMD_W-1:0] C_RELOAD = CMD_W'(4);
    localparam logic [CMD_W-1:0] C_CTRL   = CMD_W'(7);

    always_comb begin
        op_o = OP_NONE;
        if (valid_i) begin
            if (code_i == C_WRITE)       op_o = OP_WRITE;
            else if (code_i == C_READ)   op_o = OP_READ;
            else if (code_i == C_STORE)  op_o = OP_STORE;
            else if (code_i == C_RELOAD) op_o = OP_RELOAD;
            else if (code_i == C_CTRL)   op_o = OP_CTRL;
            else                         op_o = OP_NONE;
        end
    end
endmodule

// File: rtl/rheo_ctrl_reg.sv
module rheo_ctrl_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_i,
    input  logic [1:0] val_i,
    input  logic       clr_done_i,
    input  logic       ack_i,
    input  logic       ok_i,
    output logic       prog_en_o,
    output logic       wr_en_o,
    output logic       done_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_en_o <= 1'b0;
            wr_en_o   <= 1'b0;
            done_o    <= 1'b0;
        end else begin
            if (set_i) begin
                wr_en_o   <= val_i[1];
                prog_en_o <= val_i[0];
            end
            if (clr_done_i)  done_o <= 1'b0;
            else if (ack_i)  done_o <= ok_i;
        end
    end

    // R8: done only moves on a store start or an acknowledge
    assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_i && !clr_done_i) |=> $stable(done_o));
endmodule

// File: rtl/rheo_wiper_reg.sv
module rheo_wiper_reg #(
    parameter int WIDTH = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] val_i,
    output logic [WIDTH-1:0] q_o
);
    localparam logic [WIDTH-1:0] MIDSCALE = WIDTH'(1) << (WIDTH - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q_o <= MIDSCALE;
        else if (load_i) q_o <= val_i;
    end

    // R3/R7: without a load request the code holds
    assert_wiper_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(q_o));
endmodule

// File: rtl/rheo_wiper_ctrl.sv
module rheo_wiper_ctrl #(
    parameter int WIDTH = 10,
    parameter int CMD_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_op,
    input  logic [WIDTH-1:0] cmd_arg,
    input  logic             nv_present,
    input  logic [WIDTH-1:0] nv_word,
    input  logic             prog_ack,
    input  logic             prog_ok,
    output logic [WIDTH-1:0] wiper,
    output logic             store_req,
    output logic [WIDTH-1:0] store_word,
    output logic             busy,
    output logic             wr_en_bit,
    output logic             prog_en_bit,
    output logic             done_bit,
    output logic [WIDTH-1:0] rdata
);
    import rheo_pkg::*;

    localparam logic [WIDTH-1:0] MIDSCALE = WIDTH'(1) << (WIDTH - 1);

    rheo_state_t      state_q, state_d;
    rheo_op_t         op;
    logic             accept;
    logic             start_store;
    logic             wiper_load;
    logic [WIDTH-1:0] wiper_next;
    logic [WIDTH-1:0] restore_val;
    logic [WIDTH-1:0] ctrl_word;

    assign accept      = cmd_valid && (state_q == ST_IDLE);
    assign restore_val = nv_present ? nv_word : MIDSCALE;
    assign start_store = (op == OP_STORE) && prog_en_bit;
    assign ctrl_word   = {{(WIDTH-3){1'b0}}, done_bit, wr_en_bit, prog_en_bit};

    rheo_decode #(.CMD_W(CMD_W)) u_decode (
        .valid_i (accept),
        .code_i  (cmd_op),
        .op_o    (op)
    );

    rheo_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (op == OP_CTRL),
        .val_i      (cmd_arg[1:0]),
        .clr_done_i (start_store),
        .ack_i      (prog_ack && state_q == ST_LOCKED),
        .ok_i       (prog_ok),
        .prog_en_o  (prog_en_bit),
        .wr_en_o    (wr_en_bit),
        .done_o     (done_bit)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:   state_d = ST_IDLE;
            ST_IDLE:   if (start_store) state_d = ST_LOCKED;
            ST_LOCKED: if (prog_ack)    state_d = ST_IDLE;
            default:   state_d = ST_BOOT;
        endcase
    end

    // Wiper update selection
    always_comb begin
        wiper_load = 1'b0;
        wiper_next = cmd_arg;
        unique case (state_q)
            ST_BOOT: begin
                wiper_load = 1'b1;
                wiper_next = restore_val;
            end
            ST_IDLE: begin
                if (op == OP_WRITE && wr_en_bit) begin
                    wiper_load = 1'b1;
                    wiper_next = cmd_arg;
                end else if (op == OP_RELOAD) begin
                    wiper_load = 1'b1;
                    wiper_next = restore_val;
                end
            end
            default: wiper_load = 1'b0;
        endcase
    end

    rheo_wiper_reg #(.WIDTH(WIDTH)) u_wiper (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (wiper_load),
        .val_i  (wiper_next),
        .q_o    (wiper)
    );

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_req  <= 1'b0;
            store_word <= '0;
            rdata      <= '0;
        end else begin
            store_req <= start_store;
            if (start_store) store_word <= wiper;
            if (op == OP_READ) rdata <= cmd_arg[0] ? ctrl_word : wiper;
        end
    end

    assign busy = (state_q == ST_LOCKED);

    // R3: protected write leaves the wiper alone
    assert_protected_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == CMD_W'(1) && !wr_en_bit && !busy) |=> $stable(wiper));

    // R6: a request only goes out with program enable and the lock held
    assert_req_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |-> (prog_en_bit && busy));

    // R6: request is a single-cycle pulse
    assert_req_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |=> !store_req);

    // R7: nothing user-visible changes while locked without acknowledge
    assert_locked_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !prog_ack) |=> ($stable(wiper) && $stable(wr_en_bit) && $stable(prog_en_bit)
                                 && $stable(rdata) && busy));
endmodule

// File: tb/rheo_wiper_ctrl_tb.sv
module rheo_wiper_ctrl_tb;
    localparam int WIDTH = 10;
    localparam int CMD_W = 4;
    localparam int CLK_PERIOD = 10;
    localparam logic [WIDTH-1:0] MID = 10'h200;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic [CMD_W-1:0] cmd_op = '0;
    logic [WIDTH-1:0] cmd_arg = '0;
    logic             nv_present = 1'b0;
    logic [WIDTH-1:0] nv_word = '0;
    logic             prog_ack = 1'b0;
    logic             prog_ok = 1'b0;
    logic [WIDTH-1:0] wiper, store_word, rdata;
    logic             store_req, busy, wr_en_bit, prog_en_bit, done_bit;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    // model state
    logic [WIDTH-1:0] m_w = MID;
    logic             m_c0 = 1'b0, m_c1 = 1'b0, m_c2 = 1'b0;
    logic [WIDTH-1:0] m_rd = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rheo_wiper_ctrl #(.WIDTH(WIDTH), .CMD_W(CMD_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .nv_present(nv_present), .nv_word(nv_word),
        .prog_ack(prog_ack), .prog_ok(prog_ok), .wiper(wiper),
        .store_req(store_req), .store_word(store_word), .busy(busy),
        .wr_en_bit(wr_en_bit), .prog_en_bit(prog_en_bit), .done_bit(done_bit),
        .rdata(rdata)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [WIDTH-1:0] restore_val(input logic p, input logic [WIDTH-1:0] w);
        return p ? w : MID;
    endfunction

    function automatic logic [WIDTH-1:0] ctrl_word(input logic c2, input logic c1, input logic c0);
        return {{(WIDTH-3){1'b0}}, c2, c1, c0};
    endfunction

    // Model of one accepted command in the idle state (store excluded)
    task automatic model_cmd(input logic [CMD_W-1:0] op, input logic [WIDTH-1:0] arg);
        case (op)
            4'd1: if (m_c1) m_w = arg;
            4'd2: m_rd = arg[0] ? ctrl_word(m_c2, m_c1, m_c0) : m_w;
            4'd4: m_w = restore_val(nv_present, nv_word);
            4'd7: begin m_c1 = arg[1]; m_c0 = arg[0]; end
            default: ;
        endcase
    endtask

    task automatic send(input logic [CMD_W-1:0] op, input logic [WIDTH-1:0] arg);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic check_all(input string tag);
        check(wiper == m_w, {tag, " wiper"}, int'(wiper), int'(m_w));
        check({done_bit, wr_en_bit, prog_en_bit} == {m_c2, m_c1, m_c0},
              {tag, " ctrl"}, int'({done_bit, wr_en_bit, prog_en_bit}), int'({m_c2, m_c1, m_c0}));
        check(rdata == m_rd, {tag, " rdata"}, int'(rdata), int'(m_rd));
    endtask

    initial begin
        void'($urandom(32'd7719));
        // R1: reset state
        #(CLK_PERIOD * 2);
        @(negedge clk);
        check(wiper == MID, "R1 wiper in reset", int'(wiper), int'(MID));
        check({done_bit, wr_en_bit, prog_en_bit, busy, store_req} == 5'b0, "R1 flags in reset",
              int'({done_bit, wr_en_bit, prog_en_bit, busy, store_req}), 0);
        rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        check(wiper == MID, "R1 boot with no stored value", int'(wiper), int'(MID));

        // R3: protected write ignored
        send(4'd1, 10'h0AB);
        check_all("R3");

        // R4 then R2
        send(4'd7, 10'h002); model_cmd(4'd7, 10'h002);
        check_all("R4 set write enable");
        send(4'd1, 10'h0AB); model_cmd(4'd1, 10'h0AB);
        check_all("R2 write");
        send(4'd1, 10'h000); model_cmd(4'd1, 10'h000);
        check_all("R2 write zero");

        // R5: reload with protection on, no stored value then stored value
        send(4'd7, 10'h000); model_cmd(4'd7, 10'h000);
        send(4'd4, 10'h3FF); model_cmd(4'd4, 10'h3FF);
        check_all("R5 reload midscale");
        nv_present = 1'b1; nv_word = 10'h155;
        send(4'd4, 10'h000); model_cmd(4'd4, 10'h000);
        check_all("R5 reload stored");

        // R9 readback both selections
        send(4'd2, 10'h000); model_cmd(4'd2, 10'h000);
        check_all("R9 read wiper");
        send(4'd7, 10'h003); model_cmd(4'd7, 10'h003);
        send(4'd2, 10'h001); model_cmd(4'd2, 10'h001);
        check_all("R9 read control");

        // R6 store with program enable off: ignored
        send(4'd7, 10'h002); model_cmd(4'd7, 10'h002);
        send(4'd3, 10'h000);
        check(!store_req && !busy, "R6 store refused", int'({store_req, busy}), 0);

        // R6 store accepted
        send(4'd7, 10'h003); model_cmd(4'd7, 10'h003);
        send(4'd1, 10'h2C4); model_cmd(4'd1, 10'h2C4);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 4'd3; cmd_arg = '0;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(store_req && busy, "R6 request and busy", int'({store_req, busy}), 3);
        check(store_word == 10'h2C4, "R6 store word", int'(store_word), 32'h2C4);
        @(negedge clk);
        check(!store_req && busy, "R6 single pulse", int'({store_req, busy}), 1);

        // R7: commands while locked ignored
        send(4'd1, 10'h011);
        send(4'd7, 10'h000);
        send(4'd2, 10'h001);
        send(4'd4, 10'h000);
        check_all("R7 locked");
        check(busy, "R7 still busy", int'(busy), 1);

        // R8 completion, ok
        @(negedge clk); prog_ok = 1'b1; prog_ack = 1'b1;
        @(negedge clk); prog_ack = 1'b0; m_c2 = 1'b1;
        check(!busy, "R8 unlock", int'(busy), 0);
        check_all("R8 done set");

        // R8 second store clears, fails
        send(4'd3, 10'h000); m_c2 = 1'b0;
        check(done_bit == 1'b0, "R8 cleared on start", int'(done_bit), 0);
        repeat (3) @(negedge clk);
        prog_ok = 1'b0; prog_ack = 1'b1;
        @(negedge clk); prog_ack = 1'b0;
        check_all("R8 done from failed store");

        // R1 boot from stored value
        rst_n = 1'b0;
        @(negedge clk);
        nv_word = 10'h07E;
        rst_n = 1'b1;
        @(negedge clk);
        m_w = 10'h07E; m_c0 = 0; m_c1 = 0; m_c2 = 0; m_rd = '0;
        check_all("R1 boot from stored");

        // Random mix: R2 R3 R4 R5 R9 R10
        for (int i = 0; i < 400; i++) begin
            logic [CMD_W-1:0] op;
            logic [WIDTH-1:0] arg;
            op  = CMD_W'($urandom % 16);
            arg = WIDTH'($urandom);
            if (op == 4'd3) op = 4'd6;
            if (($urandom % 8) == 0) begin
                nv_present = 1'($urandom);
                nv_word = WIDTH'($urandom);
            end
            send(op, arg);
            model_cmd(op, arg);
            case (op)
                4'd1: check_all(m_c1 ? "R2 random" : "R3 random");
                4'd2: check_all("R9 random");
                4'd4: check_all("R5 random");
                4'd7: check_all("R4 random");
                default: check_all("R10 random");
            endcase
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule